// File: doc/BRIEF.md
# Two-Level Overcurrent Fault Supervisor

This block is the digital part of the overcurrent protection for a synchronous buck converter. It receives two comparator results from analog sensing: a low-side overcurrent compare, which tests the voltage across the low-side switch against a limit, and a high-side short-circuit compare, which tests the high-side switch drop against a larger multiple of that limit. It also receives the gate-drive phase requests, a pulse that marks the start of each switching period, and the enable and undervoltage-ok conditions. It passes the phase requests on to the gate drivers and removes them when a fault is found.

Each compare result counts only after a blanking interval has passed since its switch turned on. An up/down 3-bit integrator moves once per switching period. It steps up if a qualified low-side overcurrent was seen during the period, and down otherwise. A qualified short-circuit compare acts at once: it cuts the high-side pulse in the same cycle, sets the integrator to its maximum and latches the fault. The short-circuit multiplier (3x, 7x or 15x) is read from a strap code during a calibration window after start-up and is presented as a registered code to the analog threshold.

Top module: `ocp_supervisor`

## Requirements
- R1: While reset is asserted and after its release, both drive outputs are 0, the fault flag is 0, the fault count is 0 and the multiplier code is 1 (7x).
- R2: After enable and undervoltage-ok are both high, both drive outputs stay 0 for CAL_CYC clock cycles. From then on, each drive output follows its phase request.
- R3: The strap code is captured when calibration completes. Code 00 gives multiplier code 0 (3x), codes 01 and 11 give code 1 (7x), and code 10 gives code 2 (15x). Changes to the strap after calibration have no effect on the multiplier code.
- R4: A low-side compare result is ignored when the low-side request is off and during the first BLANK_CYC clock cycles after the request turns on.
- R5: When a qualified low-side overcurrent was seen during a period, the fault count rises by 1 on the clock edge that samples the period-start pulse.
- R6: When no qualified low-side overcurrent was seen during a period, the fault count falls by 1 at the period start, and it stays at 0 when it is already 0.
- R7: When the count reaches 7, the fault flag sets and both drive outputs are forced to 0. The fault stays latched and the count stays at 7 while enable and undervoltage-ok remain high.
- R8: A high-side compare result after the high-side blanking interval has expired forces the high-side drive output to 0 in the same cycle. On the next edge the count becomes 7 and the fault flag sets.
- R9: A high-side compare result during the first BLANK_CYC cycles of a high-side pulse is ignored, and the high-side drive stays on.
- R10: Dropping enable or undervoltage-ok clears the fault, the count and the calibration on the next edge, and returns the multiplier code to 1. A restart then calibrates again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Converter enable |
| uvlo_ok_i | input | 1 | Supply above the undervoltage threshold |
| cyc_start_i | input | 1 | One-cycle pulse at the start of each switching period |
| hs_on_i | input | 1 | High-side drive request from the modulator |
| ls_on_i | input | 1 | Low-side drive request from the modulator |
| ls_oc_cmp_i | input | 1 | Low-side overcurrent comparator result |
| hs_sc_cmp_i | input | 1 | High-side short-circuit comparator result |
| strap_i | input | 2 | Multiplier strap code |
| hs_drv_o | output | 1 | Gated high-side drive |
| ls_drv_o | output | 1 | Gated low-side drive |
| fault_o | output | 1 | Latched overcurrent fault |
| fault_cnt_o | output | 3 | Fault integrator count |
| mult_code_o | output | 2 | Short-circuit multiplier code (0 = 3x, 1 = 7x, 2 = 15x) |

## Verification
The bench builds the block with BLANK_CYC = 3 and CAL_CYC = 4. These values are short enough that every edge of a blanking window can be tested in a few cycles: a low-side pulse of three cycles is ignored completely, while one of four cycles gives one qualified sample. The short calibration window allows the drives to be checked while they are held off, and the strap to be changed just after capture. It also allows several restarts, so the integrator can be taken through its full range, saturation at 0, fault latching and release.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  localparam int CNT_W = 3;
  localparam logic [CNT_W-1:0] CNT_MAX = 3'd7;

  typedef enum logic [1:0] {
    MULT_X3  = 2'd0,
    MULT_X7  = 2'd1,
    MULT_X15 = 2'd2
  } mult_e;

  // Strap code to multiplier: 00 -> 3x, 10 -> 15x, 01/11 -> 7x
  function automatic mult_e strap_to_mult(input logic [1:0] code);
    case (code)
      2'b00:   return MULT_X3;
      2'b10:   return MULT_X15;
      default: return MULT_X7;
    endcase
  endfunction
endpackage

// File: rtl/ocp_blank_timer.sv
module ocp_blank_timer #(
  parameter int BLANK_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic on_i,
  output logic valid_o
);
  localparam int W = (BLANK_CYC < 1) ? 1 : $clog2(BLANK_CYC + 1);
  localparam logic [W-1:0] LIMIT = W'(BLANK_CYC);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!on_i)               cnt_d = '0;
    else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign valid_o = on_i && (cnt_q == LIMIT);
endmodule

// File: rtl/ocp_cal_ctrl.sv
module ocp_cal_ctrl
  import ocp_pkg::*;
#(
  parameter int CAL_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active_i,
  input  logic [1:0] strap_i,
  output logic       done_o,
  output logic [1:0] mult_o
);
  localparam int W = (CAL_CYC < 2) ? 1 : $clog2(CAL_CYC);
  localparam logic [W-1:0] LAST = W'(CAL_CYC - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         done_q, done_d;
  mult_e        mult_q, mult_d;
  logic         cnt_en;

  assign cnt_en = active_i && !done_q;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    mult_d = mult_q;
    if (!active_i) begin
      cnt_d  = '0;
      done_d = 1'b0;
      mult_d = MULT_X7;
    end else if (cnt_en) begin
      if (cnt_q == LAST) begin
        done_d = 1'b1;
        mult_d = strap_to_mult(strap_i);
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      mult_q <= MULT_X7;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
      mult_q <= mult_d;
    end
  end

  assign done_o = done_q;
  assign mult_o = mult_q;
endmodule

// File: rtl/ocp_fault_integ.sv
module ocp_fault_integ
  import ocp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active_i,
  input  logic             ready_i,
  input  logic             cyc_start_i,
  input  logic             ls_hit_i,
  input  logic             sc_hit_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fault_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             seen_q, seen_d;
  logic             fault_q, fault_d;
  logic             over;

  assign over = seen_q || ls_hit_i;

  always_comb begin
    cnt_d   = cnt_q;
    seen_d  = seen_q;
    fault_d = fault_q;
    if (!active_i) begin
      cnt_d   = '0;
      seen_d  = 1'b0;
      fault_d = 1'b0;
    end else if (fault_q || !ready_i) begin
      seen_d = 1'b0;
    end else if (sc_hit_i) begin
      cnt_d   = CNT_MAX;
      fault_d = 1'b1;
      seen_d  = 1'b0;
    end else if (cyc_start_i) begin
      seen_d = 1'b0;
      if (over) begin
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      end else if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end
      fault_d = (cnt_d == CNT_MAX);
    end else begin
      seen_d = over;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      seen_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      seen_q  <= seen_d;
      fault_q <= fault_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign fault_o = fault_q;
endmodule

// File: rtl/ocp_supervisor.sv
module ocp_supervisor
  import ocp_pkg::*;
#(
  parameter int BLANK_CYC = 3,
  parameter int CAL_CYC   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       uvlo_ok_i,
  input  logic       cyc_start_i,
  input  logic       hs_on_i,
  input  logic       ls_on_i,
  input  logic       ls_oc_cmp_i,
  input  logic       hs_sc_cmp_i,
  input  logic [1:0] strap_i,
  output logic       hs_drv_o,
  output logic       ls_drv_o,
  output logic       fault_o,
  output logic [2:0] fault_cnt_o,
  output logic [1:0] mult_code_o
);
  localparam int NPH = 2;

  logic             active, ready, fault, drv_ok;
  logic [NPH-1:0]   ph_on, ph_valid;
  logic             ls_hit, sc_hit;
  logic [CNT_W-1:0] cnt;

  assign active = en_i && uvlo_ok_i;
  assign ph_on  = {hs_on_i, ls_on_i};

  for (genvar g = 0; g < NPH; g++) begin : g_blank
    ocp_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_blank (
      .clk    (clk),
      .rst_n  (rst_n),
      .on_i   (ph_on[g]),
      .valid_o(ph_valid[g])
    );
  end

  assign ls_hit = ph_valid[0] && ls_oc_cmp_i;
  assign sc_hit = ph_valid[1] && hs_sc_cmp_i && ready;

  ocp_cal_ctrl #(.CAL_CYC(CAL_CYC)) u_cal (
    .clk     (clk),
    .rst_n   (rst_n),
    .active_i(active),
    .strap_i (strap_i),
    .done_o  (ready),
    .mult_o  (mult_code_o)
  );

  ocp_fault_integ u_integ (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_i   (active),
    .ready_i    (ready),
    .cyc_start_i(cyc_start_i),
    .ls_hit_i   (ls_hit),
    .sc_hit_i   (sc_hit),
    .cnt_o      (cnt),
    .fault_o    (fault)
  );

  assign drv_ok      = ready && !fault;
  assign hs_drv_o    = hs_on_i && drv_ok && !sc_hit;
  assign ls_drv_o    = ls_on_i && drv_ok;
  assign fault_o     = fault;
  assign fault_cnt_o = cnt;
endmodule

// File: rtl/ocp_supervisor_chk.sv
module ocp_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_i,
  input logic       uvlo_ok_i,
  input logic       cyc_start_i,
  input logic       hs_on_i,
  input logic       ls_on_i,
  input logic       hs_sc_cmp_i,
  input logic       hs_drv_o,
  input logic       ls_drv_o,
  input logic       fault_o,
  input logic [2:0] fault_cnt_o,
  input logic [1:0] mult_code_o
);
  p_drv_off_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (!hs_drv_o && !ls_drv_o));

  p_cnt_max_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (fault_cnt_o == 3'd7));

  p_hold_between_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && uvlo_ok_i && !cyc_start_i && !hs_sc_cmp_i) |=> $stable(fault_cnt_o));

  p_step_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && uvlo_ok_i && !fault_o && cyc_start_i && !hs_sc_cmp_i) |=>
      (({1'b0, fault_cnt_o} == {1'b0, $past(fault_cnt_o)} + 4'd1) ||
       ({1'b0, fault_cnt_o} + 4'd1 == {1'b0, $past(fault_cnt_o)}) ||
       (fault_cnt_o == $past(fault_cnt_o))));

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_i && uvlo_ok_i) |=> (fault_cnt_o == 3'd0 && !fault_o && mult_code_o == 2'd1));

  p_mult_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mult_code_o != 2'd3);

  p_drv_requested_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_on_i -> !hs_drv_o) && (!ls_on_i -> !ls_drv_o));
endmodule

bind ocp_supervisor ocp_supervisor_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_i       (en_i),
  .uvlo_ok_i  (uvlo_ok_i),
  .cyc_start_i(cyc_start_i),
  .hs_on_i    (hs_on_i),
  .ls_on_i    (ls_on_i),
  .hs_sc_cmp_i(hs_sc_cmp_i),
  .hs_drv_o   (hs_drv_o),
  .ls_drv_o   (ls_drv_o),
  .fault_o    (fault_o),
  .fault_cnt_o(fault_cnt_o),
  .mult_code_o(mult_code_o)
);

// File: tb/ocp_supervisor_test.sv
`timescale 1ns/1ps
module ocp_supervisor_test;
  localparam int BLANK = 3;
  localparam int CAL   = 4;

  logic clk = 1'b0;
  logic rst_n, en, uvlo, cyc, hs_on, ls_on, ls_cmp, hs_cmp;
  logic [1:0] strap;
  logic hs_drv, ls_drv, fault;
  logic [2:0] cnt;
  logic [1:0] mult;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  ocp_supervisor #(.BLANK_CYC(BLANK), .CAL_CYC(CAL)) uut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .uvlo_ok_i(uvlo),
    .cyc_start_i(cyc), .hs_on_i(hs_on), .ls_on_i(ls_on),
    .ls_oc_cmp_i(ls_cmp), .hs_sc_cmp_i(hs_cmp), .strap_i(strap),
    .hs_drv_o(hs_drv), .ls_drv_o(ls_drv), .fault_o(fault),
    .fault_cnt_o(cnt), .mult_code_o(mult)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #0.5;
  endtask

  task automatic idle_inputs();
    cyc = 0; hs_on = 0; ls_on = 0; ls_cmp = 0; hs_cmp = 0;
  endtask

  // low-side phase of len cycles with compare = oc, then period start
  task automatic period(input bit oc, input int len);
    @(negedge clk);
    ls_on = 1; ls_cmp = oc;
    tick(len);
    ls_on = 0; ls_cmp = 0; cyc = 1;
    tick(1);
    cyc = 0;
  endtask

  task automatic start_up(input logic [1:0] s);
    @(negedge clk);
    strap = s; en = 1; uvlo = 1;
    tick(CAL);
  endtask

  task automatic t_reset();
    rst_n = 0; en = 0; uvlo = 0; strap = 2'b00; idle_inputs();
    tick(3);
    chk("R1 hs_drv", hs_drv, 0); chk("R1 ls_drv", ls_drv, 0);
    chk("R1 fault", fault, 0);   chk("R1 cnt", cnt, 0);
    chk("R1 mult", mult, 1);
    rst_n = 1;
    tick(1);
    chk("R1 cnt after release", cnt, 0);
  endtask

  task automatic t_cal();
    @(negedge clk);
    strap = 2'b10; en = 1; uvlo = 1; ls_on = 1;
    tick(CAL - 1);
    chk("R2 ls held off in cal", ls_drv, 0);
    chk("R3 mult default in cal", mult, 1);
    tick(1);
    chk("R2 ls follows after cal", ls_drv, 1);
    chk("R3 strap 10 -> 15x", mult, 2);
    strap = 2'b00;
    tick(2);
    chk("R3 strap change ignored", mult, 2);
    ls_on = 0;
    tick(1);
    chk("R2 ls follows off", ls_drv, 0);
  endtask

  task automatic t_integrate();
    period(1, BLANK);
    chk("R4 R6 blanked hit, count stays 0", cnt, 0);
    period(0, 6);
    chk("R6 saturate at 0", cnt, 0);
    for (int k = 1; k <= 6; k++) begin
      period(1, BLANK + 1);
      chk("R5 count up", cnt, k);
    end
    chk("R5 no fault at 6", fault, 0);
    period(0, 5);
    chk("R6 count down", cnt, 5);
    period(1, BLANK + 1);
    period(1, BLANK + 1);
    chk("R7 count 7", cnt, 7);
    chk("R7 fault set", fault, 1);
    ls_on = 1; hs_on = 1;
    tick(1);
    chk("R7 ls forced off", ls_drv, 0);
    chk("R7 hs forced off", hs_drv, 0);
    ls_on = 0; hs_on = 0;
    period(0, 4);
    chk("R7 count held", cnt, 7);
    chk("R7 fault latched", fault, 1);
  endtask

  task automatic t_restart();
    @(negedge clk);
    uvlo = 0;
    tick(1);
    chk("R10 fault cleared", fault, 0);
    chk("R10 count cleared", cnt, 0);
    chk("R10 mult default", mult, 1);
    start_up(2'b00);
    chk("R3 strap 00 -> 3x", mult, 0);
    @(negedge clk); en = 0; tick(1);
    start_up(2'b11);
    chk("R3 strap 11 -> 7x", mult, 1);
    @(negedge clk); en = 0; tick(1);
    start_up(2'b01);
    chk("R3 strap 01 -> 7x", mult, 1);
  endtask

  task automatic t_short();
    @(negedge clk);
    hs_on = 1; hs_cmp = 1;
    tick(0);
    chk("R9 hs on in blanking", hs_drv, 1);
    tick(BLANK - 1);
    chk("R9 hs still on", hs_drv, 1);
    chk("R9 no fault in blanking", fault, 0);
    tick(1);
    chk("R8 hs cut same cycle", hs_drv, 0);
    chk("R8 fault not yet", fault, 0);
    tick(1);
    chk("R8 count jumps to 7", cnt, 7);
    chk("R8 fault latched", fault, 1);
    hs_on = 0; hs_cmp = 0;
    @(negedge clk); en = 0; tick(1);
    chk("R10 cleared after short", cnt, 0);
  endtask

  initial begin
    idle_inputs();
    t_reset();
    t_cal();
    t_integrate();
    t_restart();
    t_short();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual 0 expected 1");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule